// File: doc/BRIEF.md
# Transmit Run-Length Limiter

This block sits on one transmit lane, after the scrambler and before the serializer. It watches the scrambled bit stream one bit per accepted transfer and tracks how many identical bits in a row the lane has carried. If the next bit would push a run of identical values past the allowed limit of 85, the block inverts that bit. The lane therefore always has enough edges for clock recovery at the far end. Inverting a bit damages the payload, so the block raises a one-cycle flag on the same transfer as the inverted bit. Upper layers use that flag to schedule a retry.

A mode bit turns the feature off, and the stream then passes through untouched. The data path is combinational, so the output bit and the flag belong to the transfer being accepted. The handshake is a straight pass-through: `in_ready` follows `out_ready`, and `out_valid` follows `in_valid`. A bit counts as transferred only on a cycle where valid and ready are both high. When the consumer holds ready low, the producer must hold its bit, and no run state advances.

Top module: `tx_run_limiter`

## Requirements
- R1: After reset the run count is zero. The first accepted bit starts a run of length 1, whatever its value.
- R2: With limiting enabled, the first 85 identical bits of a run reach `out_bit` unchanged, and `force_pulse` stays 0.
- R3: With limiting enabled, a bit that would be the 86th identical bit in a row is inverted on `out_bit`. `force_pulse` is 1 in that same transfer cycle.
- R4: The run is counted on the output bits after any inversion. An inverted bit starts a new run of length 1 with its own polarity. With a constant input, an inversion therefore occurs on every 86th bit.
- R5: While `limit_off` is 1, `out_bit` equals `in_bit` and `force_pulse` stays 0, however long the run.
- R6: The run count saturates and never wraps. Suppose a run of 300 identical bits is sent with limiting off, and limiting is then turned on. The next bit of the same value is inverted at once.
- R7: The run count advances only on a transfer, meaning `in_valid` and `out_ready` are both 1. Idle cycles and stalled cycles inside a run do not change where the inversion falls.
- R8: Any change of bit value restarts the run at 1. A run of 85 ones, a single zero, then 85 ones produces no inversion.
- R9: `in_ready` equals `out_ready`, and `out_valid` equals `in_valid`. `force_pulse` is never 1 on a cycle without a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| limit_off | input | 1 | Mode bit: 1 disables run limiting |
| in_valid | input | 1 | Scrambled bit is present |
| in_ready | output | 1 | Block accepts the bit (mirrors out_ready) |
| in_bit | input | 1 | Scrambled data bit |
| out_valid | output | 1 | Output bit is present (mirrors in_valid) |
| out_ready | input | 1 | Serializer takes the bit |
| out_bit | output | 1 | Lane bit, possibly inverted |
| force_pulse | output | 1 | One-cycle flag: this transfer's bit was inverted |

## Verification
The hardest state to reach from the ports is a saturated run counter meeting a re-enabled limiter. Only a run far longer than the limit, built up while limiting is off, can leave the counter in that state. The bench sends 300 identical bits with limiting off, enables the feature, and expects the very next matching bit to be inverted. A wrapped counter would instead let dozens more bits pass. The stalled and idle cycles placed inside an 85-bit run check that only true transfers move the inversion point.

// File: rtl/rll_pkg.sv
package rll_pkg;
  localparam int unsigned DEF_RUN_LIMIT = 85;

  function automatic int unsigned run_cnt_width(input int unsigned limit);
    return $clog2(limit + 1) + 1;
  endfunction
endpackage

// File: rtl/rll_run_tracker.sv
module rll_run_tracker #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             bit_now,
  output logic [CNT_W-1:0] run_len,
  output logic             run_pol
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic same;
  assign same = (run_len != '0) && (bit_now == run_pol);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len <= '0;
      run_pol <= 1'b0;
    end else if (step) begin
      run_pol <= bit_now;
      if (!same)
        run_len <= ONE;
      else if (run_len != SAT)
        run_len <= run_len + ONE;
    end
  end
endmodule

// File: rtl/rll_flip_decider.sv
module rll_flip_decider #(
  parameter int unsigned RUN_LIMIT = 85,
  parameter int unsigned CNT_W     = 8
) (
  input  logic             enable,
  input  logic             cand_bit,
  input  logic             run_pol,
  input  logic [CNT_W-1:0] run_len,
  output logic             flip
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(RUN_LIMIT);

  always_comb begin
    flip = 1'b0;
    if (enable && (run_len >= LIM) && (cand_bit == run_pol))
      flip = 1'b1;
  end
endmodule

// File: rtl/tx_run_limiter.sv
module tx_run_limiter #(
  parameter int unsigned RUN_LIMIT = rll_pkg::DEF_RUN_LIMIT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic limit_off,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic force_pulse
);
  localparam int unsigned CNT_W = rll_pkg::run_cnt_width(RUN_LIMIT);

  logic             xfer;
  logic             flip;
  logic             run_pol;
  logic [CNT_W-1:0] run_len;

  assign in_ready    = out_ready;
  assign out_valid   = in_valid;
  assign xfer        = in_valid && out_ready;
  assign out_bit     = in_bit ^ flip;
  assign force_pulse = xfer && flip;

  rll_flip_decider #(.RUN_LIMIT(RUN_LIMIT), .CNT_W(CNT_W)) u_decide (
    .enable  (!limit_off),
    .cand_bit(in_bit),
    .run_pol (run_pol),
    .run_len (run_len),
    .flip    (flip)
  );

  rll_run_tracker #(.CNT_W(CNT_W)) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (xfer),
    .bit_now(out_bit),
    .run_len(run_len),
    .run_pol(run_pol)
  );
endmodule

// File: rtl/tx_run_limiter_chk.sv
module tx_run_limiter_chk #(
  parameter int unsigned RUN_LIMIT = 85
) (
  input logic clk,
  input logic rst_n,
  input logic limit_off,
  input logic in_valid,
  input logic in_ready,
  input logic in_bit,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic force_pulse
);
  logic [9:0] seen_run;
  logic       seen_pol;
  logic       xfer;
  assign xfer = in_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_run <= '0;
      seen_pol <= 1'b0;
    end else if (xfer) begin
      seen_pol <= out_bit;
      if (seen_run == '0 || out_bit != seen_pol) seen_run <= 10'd1;
      else if (seen_run != 10'h3FF) seen_run <= seen_run + 10'd1;
    end
  end

  assert_no_long_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !limit_off && seen_run >= 10'(RUN_LIMIT)) |-> (out_bit != seen_pol));

  assert_pass_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    limit_off |-> (out_bit == in_bit && !force_pulse));

  assert_flag_means_inverted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    force_pulse |-> (out_bit != in_bit));

  assert_short_run_untouched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && seen_run < 10'(RUN_LIMIT)) |-> (out_bit == in_bit && !force_pulse));

  assert_flag_only_on_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_pulse |-> (in_valid && out_ready));

  assert_ready_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready == out_ready) && (out_valid == in_valid));
endmodule

bind tx_run_limiter tx_run_limiter_chk #(.RUN_LIMIT(RUN_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .limit_off(limit_off), .in_valid(in_valid),
  .in_ready(in_ready), .in_bit(in_bit), .out_valid(out_valid),
  .out_ready(out_ready), .out_bit(out_bit), .force_pulse(force_pulse)
);

// File: tb/tb_tx_run_limiter.sv
module tb_tx_run_limiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic limit_off = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_bit, force_pulse;
  int   n_checks = 0;
  int   n_fail = 0;

  always #10 clk = ~clk;

  tx_run_limiter dut (
    .clk(clk), .rst_n(rst_n), .limit_off(limit_off), .in_valid(in_valid),
    .in_ready(in_ready), .in_bit(in_bit), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit), .force_pulse(force_pulse)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive one bit at negedge, sample mid-low phase, let posedge accept it
  task automatic send(input logic b, input logic exp_out, input logic exp_f,
                      input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_bit = b; out_ready = 1'b1;
    #3;
    check({tag, " out_bit"}, out_bit, exp_out);
    check({tag, " force_pulse"}, force_pulse, exp_f);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic t_reset_R1();
    do_reset();
    #3;
    check("R1 force idle after reset", force_pulse, 1'b0);
    send(1'b0, 1'b0, 1'b0, "R1 first bit 0");
    do_reset();
    send(1'b1, 1'b1, 1'b0, "R1 first bit 1");
  endtask

  task automatic t_limit_R2_R3_R4();
    do_reset();
    limit_off = 1'b0;
    for (int i = 0; i < 85; i++) send(1'b1, 1'b1, 1'b0, "R2 run of ones");
    send(1'b1, 1'b0, 1'b1, "R3 86th one inverted");
    for (int i = 0; i < 85; i++) send(1'b1, 1'b1, 1'b0, "R4 restart after flip");
    send(1'b1, 1'b0, 1'b1, "R4 period 86");
    do_reset();
    for (int i = 0; i < 85; i++) send(1'b0, 1'b0, 1'b0, "R2 run of zeros");
    send(1'b0, 1'b1, 1'b1, "R3 86th zero inverted");
    for (int i = 0; i < 84; i++) send(1'b1, 1'b1, 1'b0, "R4 new polarity run");
    send(1'b1, 1'b0, 1'b1, "R4 flipped bit opens run");
  endtask

  task automatic t_off_R5_R6();
    do_reset();
    limit_off = 1'b1;
    for (int i = 0; i < 300; i++) send(1'b1, 1'b1, 1'b0, "R5 off passthrough");
    limit_off = 1'b0;
    send(1'b1, 1'b0, 1'b1, "R6 saturated count forces at once");
  endtask

  task automatic t_stall_R7_R9();
    do_reset();
    for (int i = 0; i < 85; i++) begin
      send(1'b1, 1'b1, 1'b0, "R7 run with gaps");
      if (i % 10 == 3) begin
        @(negedge clk);
        in_valid = 1'b1; in_bit = 1'b1; out_ready = 1'b0;
        #3;
        check("R9 in_ready follows out_ready", in_ready, 1'b0);
        check("R9 out_valid follows in_valid", out_valid, 1'b1);
        check("R9 no flag while stalled", force_pulse, 1'b0);
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
        #3;
        check("R9 out_valid low when idle", out_valid, 1'b0);
      end
    end
    send(1'b1, 1'b0, 1'b1, "R7 inversion point unmoved");
  endtask

  task automatic t_toggle_R8();
    do_reset();
    for (int i = 0; i < 85; i++) send(1'b1, 1'b1, 1'b0, "R8 first run");
    send(1'b0, 1'b0, 1'b0, "R8 single zero");
    for (int i = 0; i < 85; i++) send(1'b1, 1'b1, 1'b0, "R8 second run");
  endtask

  initial begin
    t_reset_R1();
    t_limit_R2_R3_R4();
    t_off_R5_R6();
    t_stall_R7_R9();
    t_toggle_R8();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #3000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule